// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between a 16-bit CPU address bus and the external ROM and RAM arrays of a cartridge. Reads in the two ROM windows and the RAM window are translated into flat byte addresses for the arrays. The matching array byte is then returned on the CPU read bus. Writes into the ROM address space store nothing in the array. They load four control registers instead: a RAM enable flag, a 5-bit primary ROM bank, a 2-bit secondary bank and a mode bit.

The secondary register has two jobs. In both modes it supplies the upper bits of the switchable-window bank. In mode 1 it also moves the low ROM window and selects the RAM bank. A primary value of zero is treated as one. A multicart strap, captured at reset, moves the secondary bits down by one place and drops the top bit of the primary bank. Banks are masked to the ROM and RAM sizes given as parameters. The register state can be saved as a five-byte image and loaded back.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the primary bank, secondary bank, mode and RAM enable are all zero. The low window (0x0000–0x3FFF) reads bank 0, the switchable window (0x4000–0x7FFF) reads bank 1, and RAM-window reads return 0xFF.
- R2: A write to 0x0000–0x1FFF sets RAM enable when data[3:0] equals 0xA and clears it for any other value.
- R3: A write to 0x2000–0x3FFF loads data[4:0] as the primary bank. If the primary bank is zero, the effective primary is one. This remap is applied before the secondary bits are merged.
- R4: With the strap low, the switchable-window bank is (secondary << 5) | effective_primary, ANDed with ROM_BANKS−1. rom_addr is bank*16384 + cpu_addr[13:0].
- R5: With the strap high, the switchable-window bank is (secondary << 4) | (effective_primary & 0xF), masked the same way. So primary 0x11 with secondary 0 gives bank 1.
- R6: A write to 0x6000–0x7FFF loads data[0] as the mode bit. The low window uses bank 0 in mode 0. In mode 1 it uses secondary << 5, or secondary << 4 with the strap high, masked by ROM_BANKS−1.
- R7: A write to 0x4000–0x5FFF loads data[1:0] as the secondary bank. In mode 0 the RAM bank is 0. In mode 1 it is the secondary value ANDed with RAM_BANKS−1. ram_addr is bank*8192 + cpu_addr[12:0].
- R8: When RAM is disabled, or RAM_BANKS is 0, RAM-window (0xA000–0xBFFF) reads return 0xFF and ram_we stays low. Reads outside every window also return 0xFF.
- R9: Reads in the ROM windows return rom_rdata. Reads in the RAM window with RAM enabled return ram_rdata. A CPU write in the RAM window with RAM enabled raises ram_we in the same cycle.
- R10: save_img holds five bytes, with byte k at bits [8k+7:8k]: primary, secondary, mode, RAM enable, multicart flag. A restore_en pulse loads them, taking non-zero bytes as true for the flags, and has priority over a CPU write. Reset loads the multicart flag from the strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| multicart_strap | input | 1 | Alternate wiring select, captured at reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write enable |
| cpu_rdata | output | 8 | CPU read data |
| rom_addr | output | ROM_AW | Flat ROM byte address |
| rom_rdata | input | 8 | ROM array data |
| ram_addr | output | RAM_AW | Flat RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM array data |
| restore_en | input | 1 | Load registers from restore_img |
| restore_img | input | 40 | Five-byte state image to load |
| save_img | output | 40 | Five-byte current state image |

## Verification
The hardest state to reach from the ports is the multicart wiring combined with mode 1. It needs the strap captured at a reset, or a restored image whose fifth byte is non-zero. It also needs a mode write and a secondary write before the low window moves. The bench gets there in two ways. It pulses reset with the strap high and then runs a directed sequence. It also injects random five-byte images through the restore port, so random traffic covers both wirings in both modes. The zero-bank remap in multicart wiring, where primary 0x10 and 0x00 both give 0 in the low four bits, is also driven explicitly.

// File: rtl/cbm_pkg.sv
// Package: shared register record for the cartridge bank mapper.
// Assumes the primary bank is 5 bits and the secondary bank is 2 bits.
package cbm_pkg;
    typedef struct packed {
        logic [4:0] prim;
        logic [1:0] sec;
        logic       mode;
        logic       ram_en;
        logic       mc;
    } ctrl_t;
endpackage

// File: rtl/cbm_regs.sv
// Module: control registers for the bank mapper.
// It decodes CPU writes below 0x8000 into the four control fields.
// It captures the multicart strap at reset and handles the save/restore image.
// Assumes a restore has priority over a CPU write in the same cycle.
module cbm_regs (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mc_strap,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               restore_en,
    input  logic [39:0]        restore_img,
    output cbm_pkg::ctrl_t     ctrl,
    output logic [39:0]        save_img
);
    cbm_pkg::ctrl_t ctrl_q;
    logic           reg_wr;
    logic           unused_bits;

    assign reg_wr      = wr_en && !wr_addr[15];
    assign unused_bits = ^{wr_data[7:5], restore_img[7:5], restore_img[15:10]};

    // Register update: reset, restore, or a decoded CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q        <= '0;
            ctrl_q.mc     <= mc_strap;
        end else if (restore_en) begin
            ctrl_q.prim   <= restore_img[4:0];
            ctrl_q.sec    <= restore_img[9:8];
            ctrl_q.mode   <= (restore_img[23:16] != 8'h00);
            ctrl_q.ram_en <= (restore_img[31:24] != 8'h00);
            ctrl_q.mc     <= (restore_img[39:32] != 8'h00);
        end else if (reg_wr) begin
            case (wr_addr[14:13])
                2'd0:    ctrl_q.ram_en <= (wr_data[3:0] == 4'hA);
                2'd1:    ctrl_q.prim   <= wr_data[4:0];
                2'd2:    ctrl_q.sec    <= wr_data[1:0];
                default: ctrl_q.mode   <= wr_data[0];
            endcase
        end
    end

    assign ctrl     = ctrl_q;
    assign save_img = {7'd0, ctrl_q.mc, 7'd0, ctrl_q.ram_en, 7'd0, ctrl_q.mode,
                       6'd0, ctrl_q.sec, 3'd0, ctrl_q.prim};

    // R2: a RAM-enable write leaves the flag equal to (low nibble == 0xA).
    p_ram_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !restore_en && wr_addr[15:13] == 3'b000)
        |=> (ctrl.ram_en == ($past(wr_data[3:0]) == 4'hA)));

    // R3: a primary-bank write is stored as the low five data bits.
    p_prim_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !restore_en && wr_addr[15:13] == 3'b001)
        |=> (ctrl.prim == $past(wr_data[4:0])));

    // R10: the multicart flag only changes through reset or restore.
    p_mc_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !restore_en) |=> $stable(ctrl.mc));
endmodule

// File: rtl/cbm_translate.sv
// Module: combinational bank translation.
// It forms the flat ROM byte address for both ROM windows and the flat RAM
// byte address from the control registers.
// Assumes ROM_BANKS and RAM_BANKS are powers of two, with ROM_BANKS <= 128
// and RAM_BANKS <= 4. A value of 0 or 1 for RAM_BANKS gives no bank bits.
module cbm_translate #(
    parameter int ROM_BANKS = 64,
    parameter int RAM_BANKS = 4,
    parameter int ROM_AW    = 20,
    parameter int RAM_AW    = 15
) (
    input  cbm_pkg::ctrl_t     ctrl,
    input  logic [14:0]        addr,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [RAM_AW-1:0]  ram_addr
);
    localparam logic [6:0] ROM_MASK = 7'(ROM_BANKS - 1);
    localparam logic [1:0] RAM_MASK = (RAM_BANKS > 1) ? 2'(RAM_BANKS - 1) : 2'd0;

    logic [4:0] eff_prim;
    logic [6:0] hi_bank;
    logic [6:0] lo_bank;
    logic [6:0] sel_bank;
    logic [1:0] ram_bank;

    // Bank arithmetic for the switchable window, the low window and RAM.
    always_comb begin
        eff_prim = (ctrl.prim == 5'd0) ? 5'd1 : ctrl.prim;
        if (ctrl.mc) begin
            hi_bank = {1'b0, ctrl.sec, eff_prim[3:0]};
            lo_bank = {1'b0, ctrl.sec, 4'd0};
        end else begin
            hi_bank = {ctrl.sec, eff_prim};
            lo_bank = {ctrl.sec, 5'd0};
        end
        if (!ctrl.mode) lo_bank = 7'd0;
        sel_bank = (addr[14] ? hi_bank : lo_bank) & ROM_MASK;
        ram_bank = ctrl.mode ? (ctrl.sec & RAM_MASK) : 2'd0;
    end

    assign rom_addr = ROM_AW'({sel_bank, addr[13:0]});
    assign ram_addr = RAM_AW'({ram_bank, addr[12:0]});
endmodule

// File: rtl/cart_bank_mapper.sv
// Module: cartridge ROM/RAM bank mapper, top level.
// It decodes the CPU address into the ROM, RAM and unmapped regions.
// It steers read data, gates the RAM write strobe and instantiates the
// register and translation blocks.
// Assumes a single-cycle, combinational read path from the external arrays.
module cart_bank_mapper #(
    parameter int ROM_BANKS = 64,
    parameter int RAM_BANKS = 4,
    parameter int ROM_AW    = $clog2(ROM_BANKS) + 14,
    parameter int RAM_AW    = $clog2((RAM_BANKS > 1) ? RAM_BANKS : 1) + 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               multicart_strap,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               cpu_we,
    output logic [7:0]         cpu_rdata,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [7:0]         rom_rdata,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [7:0]         ram_wdata,
    output logic               ram_we,
    input  logic [7:0]         ram_rdata,
    input  logic               restore_en,
    input  logic [39:0]        restore_img,
    output logic [39:0]        save_img
);
    cbm_pkg::ctrl_t ctrl;
    logic           in_rom;
    logic           in_ram;
    logic           ram_live;

    cbm_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_strap    (multicart_strap),
        .wr_en       (cpu_we),
        .wr_addr     (cpu_addr),
        .wr_data     (cpu_wdata),
        .restore_en  (restore_en),
        .restore_img (restore_img),
        .ctrl        (ctrl),
        .save_img    (save_img)
    );

    cbm_translate #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS),
        .ROM_AW    (ROM_AW),
        .RAM_AW    (RAM_AW)
    ) u_xlate (
        .ctrl     (ctrl),
        .addr     (cpu_addr[14:0]),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    assign in_rom = !cpu_addr[15];
    assign in_ram = (cpu_addr[15:13] == 3'b101);

    // RAM presence is a build-time choice; without RAM the window stays dead.
    generate
        if (RAM_BANKS > 0) begin : g_ram
            assign ram_live = ctrl.ram_en;
        end else begin : g_no_ram
            assign ram_live = 1'b0;
        end
    endgenerate

    // Read steering: ROM windows, enabled RAM, or the open-bus value.
    always_comb begin
        if (in_rom)                   cpu_rdata = rom_rdata;
        else if (in_ram && ram_live)  cpu_rdata = ram_rdata;
        else                          cpu_rdata = 8'hFF;
    end

    assign ram_we    = cpu_we && in_ram && ram_live && !restore_en;
    assign ram_wdata = cpu_wdata;

    // R8: a RAM write strobe never appears while RAM is disabled.
    p_ram_we_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ctrl.ram_en);

    // R8: unmapped addresses read the open-bus value.
    p_unmapped_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rom && !in_ram) |-> (cpu_rdata == 8'hFF));

    // R6: in mode 0 the low window always lands in bank 0.
    p_low_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00 && !ctrl.mode) |-> ((rom_addr >> 14) == '0));

    // R3: the switchable window never selects bank 0 when no masking applies.
    p_hi_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01 && ROM_BANKS >= 32 && !ctrl.mc)
        |-> ((rom_addr >> 14) != '0));
endmodule

// File: tb/cart_bank_mapper_bench.sv
// Bench: random register, RAM and restore traffic mixed with directed corners.
// Every output is compared against a model kept in bench functions.
module cart_bank_mapper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROM_BANKS  = 64;
    localparam int RAM_BANKS  = 4;
    localparam int ROM_AW     = 20;
    localparam int RAM_AW     = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_we = 1'b0;
    logic [7:0]        cpu_rdata;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0]        rom_rdata;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic              ram_we;
    logic [7:0]        ram_rdata;
    logic              restore_en = 1'b0;
    logic [39:0]       restore_img = '0;
    logic [39:0]       save_img;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model registers.
    logic [4:0] m_prim;
    logic [1:0] m_sec;
    logic       m_mode, m_en, m_mc;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rom_rdata = rom_addr[7:0] ^ 8'h3C;
    assign ram_rdata = ram_addr[7:0] ^ 8'hC3;

    cart_bank_mapper #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_cart_bank_mapper (
        .clk(clk), .rst_n(rst_n), .multicart_strap(strap),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .restore_en(restore_en),
        .restore_img(restore_img), .save_img(save_img)
    );

    function automatic logic [6:0] exp_bank(input logic [15:0] a);
        logic [6:0] eff;
        logic [6:0] b;
        eff = (m_prim == 0) ? 7'd1 : {2'd0, m_prim};
        if (a[14]) b = m_mc ? (({5'd0, m_sec} << 4) | (eff & 7'h0F)) : (({5'd0, m_sec} << 5) | eff);
        else if (m_mode) b = m_mc ? ({5'd0, m_sec} << 4) : ({5'd0, m_sec} << 5);
        else b = 7'd0;
        return b & 7'(ROM_BANKS - 1);
    endfunction

    function automatic logic [ROM_AW-1:0] exp_rom(input logic [15:0] a);
        return ROM_AW'(exp_bank(a)) * 20'd16384 + ROM_AW'(a[13:0]);
    endfunction

    function automatic logic [RAM_AW-1:0] exp_ram(input logic [15:0] a);
        logic [1:0] b;
        b = m_mode ? (m_sec & 2'(RAM_BANKS - 1)) : 2'd0;
        return RAM_AW'(b) * 15'd8192 + RAM_AW'(a[12:0]);
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a);
        if (a < 16'h8000) return exp_rom(a) & 8'hFF ^ 8'h3C;
        if (a >= 16'hA000 && a < 16'hC000 && m_en) return exp_ram(a) & 8'hFF ^ 8'hC3;
        return 8'hFF;
    endfunction

    function automatic logic [39:0] exp_save();
        return {7'd0, m_mc, 7'd0, m_en, 7'd0, m_mode, 6'd0, m_sec, 3'd0, m_prim};
    endfunction

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        strap = s; rst_n = 1'b0; cpu_we = 1'b0; restore_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_prim = 0; m_sec = 0; m_mode = 0; m_en = 0; m_mc = s;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        logic exp_we;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        exp_we = (a >= 16'hA000 && a < 16'hC000 && m_en);
        #1;
        check(ram_we == exp_we, "R9 ram_we", {39'd0, ram_we}, {39'd0, exp_we});
        if (exp_we) check(ram_addr == exp_ram(a), "R7 write ram_addr", 40'(ram_addr), 40'(exp_ram(a)));
        @(negedge clk);
        cpu_we = 1'b0;
        if (a < 16'h8000) begin
            case (a[14:13])
                2'd0: m_en = (d[3:0] == 4'hA);
                2'd1: m_prim = d[4:0];
                2'd2: m_sec = d[1:0];
                default: m_mode = d[0];
            endcase
        end
    endtask

    task automatic cpu_read(input logic [15:0] a, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_we = 1'b0;
        #1;
        check(cpu_rdata == exp_rdata(a), req, 40'(cpu_rdata), 40'(exp_rdata(a)));
        if (a < 16'h8000)
            check(rom_addr == exp_rom(a), req, 40'(rom_addr), 40'(exp_rom(a)));
        if (a >= 16'hA000 && a < 16'hC000 && m_en)
            check(ram_addr == exp_ram(a), req, 40'(ram_addr), 40'(exp_ram(a)));
    endtask

    task automatic do_restore(input logic [39:0] img);
        @(negedge clk);
        restore_img = img; restore_en = 1'b1;
        @(negedge clk);
        restore_en = 1'b0;
        m_prim = img[4:0]; m_sec = img[9:8]; m_mode = img[23:16] != 0;
        m_en = img[31:24] != 0; m_mc = img[39:32] != 0;
        #1;
        check(save_img == exp_save(), "R10 restore image", save_img, exp_save());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        do_reset(1'b0);
        #1;
        check(save_img == exp_save(), "R1 reset image", save_img, exp_save());
        cpu_read(16'h0000, "R1 low window bank 0");
        cpu_read(16'h3FFF, "R1 low window end");
        cpu_read(16'h4000, "R1 switchable window bank 1");
        cpu_read(16'hA000, "R1 RAM disabled reads FF");
        cpu_write(16'hA123, 8'h55);                  // R8: disabled write, ram_we checked low
        cpu_read(16'h8000, "R8 unmapped FF");
        cpu_read(16'hC000, "R8 unmapped FF");
        cpu_write(16'h0000, 8'h1A);
        cpu_read(16'hA010, "R2 enable on nibble A");
        cpu_write(16'h1FFF, 8'h0B);
        cpu_read(16'hA010, "R2 disable on other nibble");
        cpu_write(16'h2000, 8'h02);
        cpu_read(16'h4000, "R3 primary 2");
        cpu_write(16'h2000, 8'hE0);
        cpu_read(16'h4000, "R3 zero remaps to 1");
        cpu_write(16'h4000, 8'h01);
        cpu_read(16'h4000, "R4 secondary 1 primary 0 gives 33");
        cpu_write(16'h4000, 8'h03); cpu_write(16'h3000, 8'h1F);
        cpu_read(16'h7FFF, "R4 bank masked to 63");
        cpu_write(16'h6000, 8'h01); cpu_write(16'h4000, 8'h01);
        cpu_read(16'h0000, "R6 mode 1 low window 32");
        cpu_write(16'h0000, 8'h0A);
        cpu_write(16'hA000, 8'hAA);
        cpu_write(16'h4000, 8'h02);
        cpu_read(16'hBFFF, "R7 RAM bank 2 in mode 1");
        cpu_write(16'h6000, 8'h00);
        cpu_read(16'hA000, "R7 RAM bank 0 in mode 0");
        cpu_read(16'h0100, "R6 mode 0 low window 0");
        check(save_img == exp_save(), "R10 save image", save_img, exp_save());

        do_reset(1'b1);
        cpu_write(16'h4000, 8'h01); cpu_write(16'h2000, 8'h01);
        cpu_read(16'h4000, "R5 multicart gives 17");
        cpu_write(16'h4000, 8'h00); cpu_write(16'h2000, 8'h11);
        cpu_read(16'h4000, "R5 multicart drops primary bit 4");
        cpu_write(16'h2000, 8'h10);
        cpu_read(16'h4000, "R5 multicart primary 0x10 gives 0");
        cpu_write(16'h6000, 8'h01); cpu_write(16'h4000, 8'h01);
        cpu_read(16'h0000, "R6 multicart mode 1 low window 16");
        check(save_img == exp_save(), "R10 strap flag saved", save_img, exp_save());
        do_restore(40'h00_01_00_02_1F);
        cpu_read(16'h4000, "R10 restored normal wiring");

        for (int i = 0; i < 1500; i++) begin
            logic [15:0] a;
            case ($urandom % 7)
                0: a = 16'h0000 | 16'($urandom & 32'h1FFF);
                1: a = 16'h2000 | 16'($urandom & 32'h1FFF);
                2: a = 16'h4000 | 16'($urandom & 32'h1FFF);
                3: a = 16'h6000 | 16'($urandom & 32'h1FFF);
                4: a = 16'hA000 | 16'($urandom & 32'h1FFF);
                default: a = 16'($urandom);
            endcase
            case ($urandom % 8)
                0, 1, 2: cpu_write(a, 8'($urandom));
                3: do_restore({7'd0, 1'($urandom), 7'd0, 1'($urandom), 7'd0, 1'($urandom),
                               6'd0, 2'($urandom), 3'd0, 5'($urandom)});
                default: cpu_read(a, "R9 random read");
            endcase
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule